// File: doc/BRIEF.md
# Host Command and Status Handshake Registers

This block sits between a host and the two internal engines of a network controller: a receive engine and a command (transmit) engine. The host sees two 16-bit words. The status word collects event flags that stay set until the host writes a one over them. It also shows the current state of both engines, passed straight through from their state inputs. The command word holds one pending command for each engine, an interrupt mask and a software-interrupt trigger.

A command is issued by writing the command word. Each command field keeps its value until the engine it addresses returns a one-cycle accept pulse. The field then reads zero again, so the host polls for zero to learn that the command was taken. The interrupt output is raised while any event flag is pending and the mask bit is clear.

Top module: `host_cmd_status`

## Requirements
- R1: After reset every event flag, both command fields and the mask bit are 0, and `irq` is 0.
- R2: A one-cycle pulse on an event input sets its flag in the status word on the next clock, and the flag stays set with no further pulse. Positions: 15 command done, 14 frame received, 13 command engine left active, 12 receiver left ready, 11 management cycle done, 8 flow-control pause.
- R3: A status write clears each event flag whose data bit is 1 and leaves flags written with 0 unchanged. Data bits outside the event mask 0xFD00 have no effect.
- R4: If an event pulse and a status write that clears the same flag fall in one cycle, the flag stays set.
- R5: A command write loads the receive command from data bits 2:0 (0 nop, 1 start, 2 resume, 4 abort, 6 load base, 7 resume without resources). The field holds until `ru_accept` pulses, then reads 0. `cu_accept` leaves it untouched.
- R6: A command write loads the command-engine command from data bits 7:4 (0 nop, 1 start, 2 resume, 4 load stats address, 5 dump stats, 6 load base, 7 dump and reset). It holds until `cu_accept` pulses, then reads 0. `ru_accept` leaves it untouched.
- R7: Command bit 8 is the interrupt mask and reads back as written. `irq` is 1 exactly when some event flag is pending and the mask is 0.
- R8: A command write with bit 9 set raises the software-interrupt flag at status bit 10. Command bit 9 itself always reads 0.
- R9: Status bits 5:2 show `ru_state` (idle 0, suspended 1, no resources 2, ready 4, plus 8 for out of buffer descriptors). Bits 7:6 show `cu_state`. Both follow the inputs in the same cycle. Status bits 9, 1 and 0 read 0.
- R10: When a command write and an accept for the same engine fall in one cycle, the newly written command is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stat_en | input | 1 | Host write strobe for the status word (write-one-to-clear) |
| wr_cmd_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 16 | Host write data |
| ev_cmd_done | input | 1 | Event pulse: command finished |
| ev_frame_rx | input | 1 | Event pulse: frame received |
| ev_cu_left | input | 1 | Event pulse: command engine left active state |
| ev_rx_halt | input | 1 | Event pulse: receiver left ready state |
| ev_mgmt_done | input | 1 | Event pulse: management cycle done |
| ev_fc_pause | input | 1 | Event pulse: flow-control pause |
| ru_state | input | 4 | Receive engine state code |
| cu_state | input | 2 | Command engine state code |
| ru_accept | input | 1 | Receive engine took its command |
| cu_accept | input | 1 | Command engine took its command |
| stat_rd | output | 16 | Status word |
| cmd_rd | output | 16 | Command word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the collisions. One is an event arriving in the very clock of a host clear of the same flag. The other is an accept arriving in the very clock of a fresh command write. The stimulus drives both inputs on one falling edge, so the same rising edge registers both. It then reads the result on the following falling edge. The bench also pulses one engine's accept while both fields are loaded, which shows that the other field is left alone.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] EVT_KEEP = 16'hFD00;

    localparam int B_CMD_DONE = 15;
    localparam int B_FRAME_RX = 14;
    localparam int B_CU_LEFT  = 13;
    localparam int B_RX_HALT  = 12;
    localparam int B_MGMT     = 11;
    localparam int B_SWI_EVT  = 10;
    localparam int B_FC_PAUSE = 8;

    localparam int RU_CMD_LO = 0;
    localparam int RU_CMD_W  = 3;
    localparam int CU_CMD_LO = 4;
    localparam int CU_CMD_W  = 4;
    localparam int MASK_BIT  = 8;
    localparam int SWI_BIT   = 9;

    localparam int RU_ST_W = 4;
    localparam int CU_ST_W = 2;

    typedef struct packed {
        logic mask;
    } ctl_t;
endpackage

// File: rtl/hcs_event_bank.sv
module hcs_event_bank #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   KEEP = 16'hFD00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [W-1:0] pend;
    } bank_t;

    bank_t        bank_d, bank_q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (KEEP[i]) begin : g_live
            // an arriving event beats a clear in the same cycle
            assign nxt[i] = set_i[i] | (bank_q.pend[i] & ~clr_i[i]);
        end else begin : g_dead
            assign nxt[i] = 1'b0;
        end
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.pend = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign pend_o = bank_q.pend;

    a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & KEEP) != '0) |=> ((pend_o & $past(set_i & KEEP)) == $past(set_i & KEEP)));

    a_r3_clear_ones_only: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> (pend_o == ($past(pend_o) & ~$past(clr_i))));
endmodule

// File: rtl/hcs_cmd_slot.sv
module hcs_cmd_slot #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         take_i,
    output logic [W-1:0] cmd_o
);
    typedef struct packed {
        logic [W-1:0] cmd;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take_i) slot_d.cmd = '0;
        if (load_i) slot_d.cmd = val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign cmd_o = slot_q.cmd;

    a_r5_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !take_i) |=> $stable(cmd_o));

    a_r5_cmd_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !load_i) |=> (cmd_o == '0));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cmd_o == $past(val_i)));
endmodule

// File: rtl/host_cmd_status.sv
module host_cmd_status
    import hcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stat_en,
    input  logic        wr_cmd_en,
    input  logic [15:0] wr_data,
    input  logic        ev_cmd_done,
    input  logic        ev_frame_rx,
    input  logic        ev_cu_left,
    input  logic        ev_rx_halt,
    input  logic        ev_mgmt_done,
    input  logic        ev_fc_pause,
    input  logic [3:0]  ru_state,
    input  logic [1:0]  cu_state,
    input  logic        ru_accept,
    input  logic        cu_accept,
    output logic [15:0] stat_rd,
    output logic [15:0] cmd_rd,
    output logic        irq
);
    logic [WORD_W-1:0]   set_vec, clr_vec, pend;
    logic [RU_CMD_W-1:0] ru_cmd;
    logic [CU_CMD_W-1:0] cu_cmd;
    ctl_t                ctl_d, ctl_q;

    always_comb begin
        set_vec             = '0;
        set_vec[B_CMD_DONE] = ev_cmd_done;
        set_vec[B_FRAME_RX] = ev_frame_rx;
        set_vec[B_CU_LEFT]  = ev_cu_left;
        set_vec[B_RX_HALT]  = ev_rx_halt;
        set_vec[B_MGMT]     = ev_mgmt_done;
        set_vec[B_FC_PAUSE] = ev_fc_pause;
        set_vec[B_SWI_EVT]  = wr_cmd_en & wr_data[SWI_BIT];
        clr_vec             = wr_stat_en ? wr_data : '0;
    end

    hcs_event_bank #(.W(WORD_W), .KEEP(EVT_KEEP)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    hcs_cmd_slot #(.W(RU_CMD_W)) u_ru_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wr_cmd_en),
        .val_i  (wr_data[RU_CMD_LO +: RU_CMD_W]),
        .take_i (ru_accept),
        .cmd_o  (ru_cmd)
    );

    hcs_cmd_slot #(.W(CU_CMD_W)) u_cu_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wr_cmd_en),
        .val_i  (wr_data[CU_CMD_LO +: CU_CMD_W]),
        .take_i (cu_accept),
        .cmd_o  (cu_cmd)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_cmd_en) ctl_d.mask = wr_data[MASK_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign stat_rd = pend | {8'h00, cu_state, ru_state, 2'b00};
    assign cmd_rd  = {7'h00, ctl_q.mask, cu_cmd, 1'b0, ru_cmd};
    assign irq     = !ctl_q.mask && (pend != '0);

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd[MASK_BIT] |-> !irq);

    a_r8_swi_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_en && wr_data[SWI_BIT]) |=> stat_rd[B_SWI_EVT]);

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd[9] == 1'b0) && (stat_rd[1:0] == 2'b00) && (cmd_rd[SWI_BIT] == 1'b0));
endmodule

// File: tb/host_cmd_status_test.sv
module host_cmd_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stat_en = 1'b0, wr_cmd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ev_cmd_done = 0, ev_frame_rx = 0, ev_cu_left = 0;
    logic        ev_rx_halt = 0, ev_mgmt_done = 0, ev_fc_pause = 0;
    logic [3:0]  ru_state = '0;
    logic [1:0]  cu_state = '0;
    logic        ru_accept = 0, cu_accept = 0;
    logic [15:0] stat_rd, cmd_rd;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    host_cmd_status uut (
        .clk(clk), .rst_n(rst_n), .wr_stat_en(wr_stat_en), .wr_cmd_en(wr_cmd_en),
        .wr_data(wr_data), .ev_cmd_done(ev_cmd_done), .ev_frame_rx(ev_frame_rx),
        .ev_cu_left(ev_cu_left), .ev_rx_halt(ev_rx_halt), .ev_mgmt_done(ev_mgmt_done),
        .ev_fc_pause(ev_fc_pause), .ru_state(ru_state), .cu_state(cu_state),
        .ru_accept(ru_accept), .cu_accept(cu_accept),
        .stat_rd(stat_rd), .cmd_rd(cmd_rd), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_stat(input logic [15:0] v);
        wr_stat_en = 1; wr_data = v; step(); wr_stat_en = 0; wr_data = '0;
    endtask

    task automatic wr_cmd(input logic [15:0] v);
        wr_cmd_en = 1; wr_data = v; step(); wr_cmd_en = 0; wr_data = '0;
    endtask

    task automatic pulse_all();
        ev_cmd_done = 1; ev_frame_rx = 1; ev_cu_left = 1;
        ev_rx_halt = 1; ev_mgmt_done = 1; ev_fc_pause = 1;
        step();
        ev_cmd_done = 0; ev_frame_rx = 0; ev_cu_left = 0;
        ev_rx_halt = 0; ev_mgmt_done = 0; ev_fc_pause = 0;
    endtask

    task automatic t_reset();
        chk("R1 status after reset", stat_rd, 16'h0000);
        chk("R1 command after reset", cmd_rd, 16'h0000);
        chk("R1 irq after reset", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_events();
        ev_frame_rx = 1; step(); ev_frame_rx = 0;
        chk("R2 frame flag set", stat_rd, 16'h4000);
        step();
        chk("R2 frame flag sticky", stat_rd, 16'h4000);
        chk("R7 irq with pending flag", {15'b0, irq}, 16'h0001);
        wr_stat(16'hFFFF);
        ev_fc_pause = 1; step(); ev_fc_pause = 0;
        chk("R2 pause flag at bit 8", stat_rd, 16'h0100);
        wr_stat(16'hFFFF);
        chk("R7 irq drops when clear", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_w1c();
        pulse_all();
        chk("R2 all event positions", stat_rd, 16'hF900);
        wr_stat(16'h4100);
        chk("R3 ones clear", stat_rd, 16'hB800);
        wr_stat(16'h0000);
        chk("R3 zeros keep", stat_rd, 16'hB800);
        wr_stat(16'h02FF);
        chk("R3 bits outside mask ignored", stat_rd, 16'hB800);
        wr_stat(16'hFFFF);
        chk("R3 full clear", stat_rd, 16'h0000);
    endtask

    task automatic t_collide();
        ev_cmd_done = 1; ev_frame_rx = 1; step();
        ev_cmd_done = 0; ev_frame_rx = 1;
        wr_stat_en = 1; wr_data = 16'hFD00; step();
        ev_frame_rx = 0; wr_stat_en = 0; wr_data = '0;
        chk("R4 event beats clear", stat_rd, 16'h4000);
        wr_stat(16'hFFFF);
    endtask

    task automatic t_ru_cmd();
        wr_cmd(16'h0001);
        chk("R5 receive command loaded", cmd_rd, 16'h0001);
        step(); step();
        chk("R5 receive command holds", cmd_rd, 16'h0001);
        cu_accept = 1; step(); cu_accept = 0;
        chk("R5 other accept ignored", cmd_rd, 16'h0001);
        ru_accept = 1; step(); ru_accept = 0;
        chk("R5 accept clears field", cmd_rd, 16'h0000);
    endtask

    task automatic t_cu_cmd();
        wr_cmd(16'h0076);
        chk("R6 both fields loaded", cmd_rd, 16'h0076);
        cu_accept = 1; step(); cu_accept = 0;
        chk("R6 command field cleared alone", cmd_rd, 16'h0006);
        ru_accept = 1; step(); ru_accept = 0;
        chk("R6 receive field cleared after", cmd_rd, 16'h0000);
        wr_cmd(16'h0040);
        ru_accept = 1; step(); ru_accept = 0;
        chk("R6 receive accept leaves command field", cmd_rd, 16'h0040);
        cu_accept = 1; step(); cu_accept = 0;
    endtask

    task automatic t_mask();
        ev_mgmt_done = 1; step(); ev_mgmt_done = 0;
        wr_cmd(16'h0100);
        chk("R7 mask reads back", cmd_rd, 16'h0100);
        chk("R7 masked irq low", {15'b0, irq}, 16'h0000);
        wr_cmd(16'h0000);
        chk("R7 unmasked irq high", {15'b0, irq}, 16'h0001);
        wr_stat(16'hFFFF);
    endtask

    task automatic t_swi();
        wr_cmd(16'h0200);
        chk("R8 software flag at bit 10", stat_rd, 16'h0400);
        chk("R8 trigger bit reads zero", cmd_rd, 16'h0000);
        chk("R8 software flag raises irq", {15'b0, irq}, 16'h0001);
        wr_stat(16'h0400);
        chk("R8 software flag clears", stat_rd, 16'h0000);
    endtask

    task automatic t_state();
        ru_state = 4'hC; cu_state = 2'h2; #1;
        chk("R9 state fields", stat_rd, 16'h00B0);
        ru_state = 4'h1; cu_state = 2'h1; #1;
        chk("R9 state follows inputs", stat_rd, 16'h0044);
        ru_state = '0; cu_state = '0; step();
    endtask

    task automatic t_write_accept();
        wr_cmd(16'h0011);
        wr_cmd_en = 1; wr_data = 16'h0022; ru_accept = 1; cu_accept = 1; step();
        wr_cmd_en = 0; wr_data = '0; ru_accept = 0; cu_accept = 0;
        chk("R10 new command kept over accept", cmd_rd, 16'h0022);
        ru_accept = 1; cu_accept = 1; step(); ru_accept = 0; cu_accept = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_events();
        t_w1c();
        t_collide();
        t_ru_cmd();
        t_cu_cmd();
        t_mask();
        t_swi();
        t_state();
        t_write_accept();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule